// File: doc/BRIEF.md
# Auto-Increment Byte Programming Sequencer

This block runs the self-timed byte programming engine of a serial flash model. The serial front end passes in each command only after chip select has risen: the opcode, flags that say whether three address bytes and a data byte arrived, the address and the data. The block decides whether to start a program operation. It keeps the auto-increment address pointer and runs a busy timer of fixed length for each byte. When the timer finishes, it writes the byte into a small array model.

There are two ways to program. A single-byte program (opcode 02h) carries its own address. An auto-increment session starts with AFh plus an address and a data byte. After that, each byte arrives as AFh plus a data byte only, and the address is implied by the pointer. The session ends on a write-disable command (04h). It also ends, without wrapping, once the highest unprotected address has been programmed.

The write-enable latch and the protection settings live in a neighbouring status block. This block reads the latch on `wel_i` and asks for it to be cleared with a one-cycle pulse on `wel_clr_o`. Protection arrives as a boundary: every address at or above `prot_bound_i` is protected.

Top module: `autoinc_prog_seq`

## Requirements
- R1: After reset, busy_o, aai_o and wel_clr_o are 0, and every array byte reads FFh.
- R2: An idle command with opcode 02h, address and data present, wel_i=1, an unprotected address and aai_o=0 programs that byte. When it completes, wel_clr_o pulses for one cycle and aai_o stays 0.
- R3: A program command (02h or the opening AFh) received while wel_i=0 is ignored: busy_o stays 0 and the array is unchanged.
- R4: An accepted program command raises busy_o in the cycle after the one in which cmd_valid_i is high.
- R5: busy_o stays high for exactly PROG_CYCLES cycles. The array byte and any wel_clr_o pulse change in the cycle in which busy_o falls.
- R6: Programming stores the old byte AND the data byte, so bits can be cleared but never set.
- R7: An idle AFh with address and data, wel_i=1 and an unprotected address sets aai_o from the next cycle and programs that address.
- R8: While aai_o=1, an AFh carrying a data byte and no address bytes programs the address one above the last one programmed. An AFh that carries address bytes inside a session is ignored. An address-less AFh outside a session is also ignored.
- R9: While busy_o=1, every command is discarded, including 04h. The pointer, aai_o and the array are affected only by the operation in progress.
- R10: An idle 04h clears aai_o and pulses wel_clr_o in the next cycle.
- R11: An address A is protected when A >= prot_bound_i. Any program, session start or continuation aimed at a protected address is ignored.
- R12: When a session byte at address prot_bound_i-1 completes, aai_o falls and wel_clr_o pulses in the same cycle, with no wrap. Later address-less AFh commands are ignored.
- R13: Opcode 02h received while aai_o=1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | One-cycle strobe: a complete command was delivered (chip select has risen) |
| cmd_opcode_i | input | 8 | Command opcode |
| cmd_addr_ok_i | input | 1 | Three address bytes were received |
| cmd_data_ok_i | input | 1 | A data byte was received |
| cmd_addr_i | input | AW | Received address |
| cmd_data_i | input | 8 | Received data byte |
| wel_i | input | 1 | Write-enable latch from the status block |
| prot_bound_i | input | AW+1 | First protected address; equal to 2^AW when nothing is protected |
| rd_addr_i | input | AW | Array read address |
| rd_data_o | output | 8 | Array read data |
| busy_o | output | 1 | Program operation in progress |
| aai_o | output | 1 | Auto-increment session active |
| wel_clr_o | output | 1 | One-cycle request to clear the write-enable latch |

## Verification
A wrong pointer does not show up while the session runs. It appears only at the next address-less AFh, which then writes a byte at the wrong place in the array. For that reason the bench compares the whole array after every group of commands. A timer that is off by one cycle shows at once in the length of busy_o. A missed exit condition leaves aai_o high and wel_clr_o silent in the cycle where busy_o falls after the top unprotected byte, and that cycle is sampled directly. A command that should have been discarded while busy shows later, either as an extra written byte or as a shifted pointer on the next continuation.

// File: rtl/autoinc_prog_pkg.sv
package autoinc_prog_pkg;
  localparam logic [7:0] OP_BYTE_PROG = 8'h02;
  localparam logic [7:0] OP_AUTO_PROG = 8'hAF;
  localparam logic [7:0] OP_WR_DIS    = 8'h04;
  localparam logic [7:0] ERASED_BYTE  = 8'hFF;
endpackage

// File: rtl/prog_timer.sv
module prog_timer #(
  parameter int unsigned CYCLES = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= CW'(CYCLES - 1);
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == '0);
endmodule

// File: rtl/prog_cmd_decode.sv
module prog_cmd_decode
  import autoinc_prog_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic          valid_i,
  input  logic [7:0]    opcode_i,
  input  logic          addr_ok_i,
  input  logic          data_ok_i,
  input  logic [AW-1:0] addr_i,
  input  logic          wel_i,
  input  logic          busy_i,
  input  logic          aai_i,
  input  logic [AW-1:0] ptr_i,
  input  logic [AW:0]   bound_i,
  output logic          start_o,
  output logic          start_aai_o,
  output logic [AW-1:0] tgt_addr_o,
  output logic          wrdi_o
);
  logic idle_cmd, addr_free, ptr_free, full_form;
  logic bp_ok, aai_first, aai_next;

  always_comb begin
    idle_cmd  = valid_i && !busy_i;
    addr_free = {1'b0, addr_i} < bound_i;
    ptr_free  = {1'b0, ptr_i} < bound_i;
    full_form = addr_ok_i && data_ok_i;

    bp_ok     = idle_cmd && (opcode_i == OP_BYTE_PROG) && full_form && !aai_i
                && wel_i && addr_free;
    aai_first = idle_cmd && (opcode_i == OP_AUTO_PROG) && full_form && !aai_i
                && wel_i && addr_free;
    // continuation: data only, address implied by pointer
    aai_next  = idle_cmd && (opcode_i == OP_AUTO_PROG) && aai_i && !addr_ok_i
                && data_ok_i && ptr_free;

    start_o     = bp_ok || aai_first || aai_next;
    start_aai_o = aai_first;
    tgt_addr_o  = aai_next ? ptr_i : addr_i;
    wrdi_o      = idle_cmd && (opcode_i == OP_WR_DIS);
  end
endmodule

// File: rtl/byte_array.sv
module byte_array
  import autoinc_prog_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= ERASED_BYTE;
    end else if (we_i) begin
      mem_q[waddr_i] <= mem_q[waddr_i] & wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/autoinc_prog_seq.sv
module autoinc_prog_seq
  import autoinc_prog_pkg::*;
#(
  parameter int unsigned AW          = 8,
  parameter int unsigned PROG_CYCLES = 1000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_valid_i,
  input  logic [7:0]    cmd_opcode_i,
  input  logic          cmd_addr_ok_i,
  input  logic          cmd_data_ok_i,
  input  logic [AW-1:0] cmd_addr_i,
  input  logic [7:0]    cmd_data_i,
  input  logic          wel_i,
  input  logic [AW:0]   prot_bound_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [7:0]    rd_data_o,
  output logic          busy_o,
  output logic          aai_o,
  output logic          wel_clr_o
);
  logic          busy, done, start, start_aai, wrdi;
  logic [AW-1:0] tgt_addr;
  logic          aai_q, pend_aai_q, wel_clr_q;
  logic [AW-1:0] ptr_q, pend_addr_q;
  logic [7:0]    pend_data_q;
  logic          at_top;

  prog_cmd_decode #(.AW(AW)) u_dec (
    .valid_i    (cmd_valid_i),
    .opcode_i   (cmd_opcode_i),
    .addr_ok_i  (cmd_addr_ok_i),
    .data_ok_i  (cmd_data_ok_i),
    .addr_i     (cmd_addr_i),
    .wel_i      (wel_i),
    .busy_i     (busy),
    .aai_i      (aai_q),
    .ptr_i      (ptr_q),
    .bound_i    (prot_bound_i),
    .start_o    (start),
    .start_aai_o(start_aai),
    .tgt_addr_o (tgt_addr),
    .wrdi_o     (wrdi)
  );

  prog_timer #(.CYCLES(PROG_CYCLES)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start),
    .busy_o (busy),
    .done_o (done)
  );

  byte_array #(.AW(AW)) u_arr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (done),
    .waddr_i(pend_addr_q),
    .wdata_i(pend_data_q),
    .raddr_i(rd_addr_i),
    .rdata_o(rd_data_o)
  );

  // last unprotected byte reached: no wrap, session ends
  assign at_top = ({1'b0, pend_addr_q} == (prot_bound_i - 1'b1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      aai_q       <= 1'b0;
      ptr_q       <= '0;
      pend_addr_q <= '0;
      pend_data_q <= ERASED_BYTE;
      pend_aai_q  <= 1'b0;
      wel_clr_q   <= 1'b0;
    end else begin
      wel_clr_q <= 1'b0;
      if (start) begin
        pend_addr_q <= tgt_addr;
        pend_data_q <= cmd_data_i;
        pend_aai_q  <= start_aai || aai_q;
        if (start_aai) aai_q <= 1'b1;
      end
      if (done) begin
        if (pend_aai_q) begin
          ptr_q <= pend_addr_q + 1'b1;
          if (at_top) begin
            aai_q     <= 1'b0;
            wel_clr_q <= 1'b1;
          end
        end else begin
          wel_clr_q <= 1'b1;
        end
      end
      if (wrdi) begin
        aai_q     <= 1'b0;
        wel_clr_q <= 1'b1;
      end
    end
  end

  assign busy_o    = busy;
  assign aai_o     = aai_q;
  assign wel_clr_o = wel_clr_q;
endmodule

// File: rtl/autoinc_prog_seq_chk.sv
module autoinc_prog_seq_chk #(
  parameter int unsigned PROG_CYCLES = 1000
) (
  input logic clk_i,
  input logic rst_ni,
  input logic cmd_valid_i,
  input logic busy_o,
  input logic aai_o,
  input logic wel_clr_o
);
  logic [31:0] busy_len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_len_q <= '0;
    else if (busy_o) busy_len_q <= busy_len_q + 1'b1;
    else             busy_len_q <= '0;
  end

  assert_start_after_cmd_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(cmd_valid_i));

  assert_busy_len_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (busy_len_q == PROG_CYCLES));

  assert_clr_not_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wel_clr_o |-> !busy_o);

  assert_aai_entry_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(aai_o) |-> $rose(busy_o));

  assert_aai_steady_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(aai_o));

  assert_aai_exit_clr_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(aai_o) |-> wel_clr_o);
endmodule

bind autoinc_prog_seq autoinc_prog_seq_chk #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cmd_valid_i(cmd_valid_i),
  .busy_o     (busy_o),
  .aai_o      (aai_o),
  .wel_clr_o  (wel_clr_o)
);

// File: tb/autoinc_prog_seq_bench.sv
`timescale 1ns/1ps
module autoinc_prog_seq_bench;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;
  localparam int P = 5;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cmd_valid_i = 1'b0;
  logic [7:0] cmd_opcode_i = '0;
  logic cmd_addr_ok_i = 1'b0, cmd_data_ok_i = 1'b0;
  logic [AW-1:0] cmd_addr_i = '0;
  logic [7:0] cmd_data_i = '0;
  logic wel_i = 1'b0;
  logic [AW:0] prot_bound_i = (AW+1)'(DEPTH);
  logic [AW-1:0] rd_addr_i = '0;
  logic [7:0] rd_data_o;
  logic busy_o, aai_o, wel_clr_o;

  logic [7:0] mdl [DEPTH];
  int tests = 0, fails = 0;

  always #10 clk = ~clk;

  autoinc_prog_seq #(.AW(AW), .PROG_CYCLES(P)) u_autoinc_prog_seq (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i), .cmd_opcode_i(cmd_opcode_i),
    .cmd_addr_ok_i(cmd_addr_ok_i), .cmd_data_ok_i(cmd_data_ok_i), .cmd_addr_i(cmd_addr_i),
    .cmd_data_i(cmd_data_i), .wel_i(wel_i), .prot_bound_i(prot_bound_i),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o), .busy_o(busy_o), .aai_o(aai_o),
    .wel_clr_o(wel_clr_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cmd(input logic [7:0] op, input bit aok, input bit dok,
                     input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    cmd_opcode_i = op; cmd_addr_ok_i = aok; cmd_data_ok_i = dok;
    cmd_addr_i = a; cmd_data_i = d; cmd_valid_i = 1'b1;
    @(negedge clk);
    cmd_valid_i = 1'b0;
  endtask

  // called at the negedge right after cmd()
  task automatic expect_prog(input bit started, input bit exp_clr, input string tag);
    int n = 0;
    check(busy_o == started, {tag, " busy start"}, busy_o, started);
    while (busy_o && n < 100) begin
      n++;
      @(negedge clk);
    end
    if (started) begin
      check(n == P, {tag, " busy length R5"}, n, P);
      check(wel_clr_o == exp_clr, {tag, " wel_clr at completion"}, wel_clr_o, exp_clr);
    end else begin
      check(wel_clr_o == 1'b0, {tag, " no wel_clr"}, wel_clr_o, 0);
    end
    if (wel_clr_o) wel_i = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy_o && n < 100) begin n++; @(negedge clk); end
    if (wel_clr_o) wel_i = 1'b0;
  endtask

  task automatic cmp_array(input string tag);
    for (int i = 0; i < DEPTH; i++) begin
      rd_addr_i = AW'(i);
      #1;
      check(rd_data_o == mdl[i], {tag, " array byte"}, rd_data_o, mdl[i]);
    end
  endtask

  initial begin
    #(20 * 150000);
    $display("FAIL watchdog expired");
    fails++;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) mdl[i] = 8'hFF;
    repeat (3) @(negedge clk);
    check(busy_o == 0 && aai_o == 0 && wel_clr_o == 0, "R1 reset outputs",
          {busy_o, aai_o, wel_clr_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    cmp_array("R1 erased");

    // R3: no write enable
    wel_i = 0;
    cmd(8'h02, 1, 1, 3, 8'h5A);
    expect_prog(0, 0, "R3 byte prog without wel");
    cmd(8'hAF, 1, 1, 3, 8'h5A);
    expect_prog(0, 0, "R3 aai start without wel");
    check(aai_o == 0, "R3 aai stays 0", aai_o, 0);
    cmp_array("R3");

    // R2 R4 R5
    wel_i = 1;
    cmd(8'h02, 1, 1, 3, 8'hA5);
    check(aai_o == 0, "R2 aai stays 0", aai_o, 0);
    expect_prog(1, 1, "R2 byte prog");
    mdl[3] &= 8'hA5;
    cmp_array("R2");

    // R6
    wel_i = 1;
    cmd(8'h02, 1, 1, 3, 8'h3C);
    expect_prog(1, 1, "R6 reprogram");
    mdl[3] &= 8'h3C;
    check(mdl[3] == 8'h24, "R6 model", mdl[3], 8'h24);
    cmp_array("R6");

    // R11 protected byte program
    prot_bound_i = 8; wel_i = 1;
    cmd(8'h02, 1, 1, 10, 8'h00);
    expect_prog(0, 0, "R11 protected prog");
    cmd(8'hAF, 1, 1, 8, 8'h00);
    expect_prog(0, 0, "R11 protected aai start");
    cmp_array("R11");
    prot_bound_i = 16;

    // R7 R8 session
    cmd(8'hAF, 1, 1, 5, 8'h11);
    check(aai_o == 1, "R7 aai set", aai_o, 1);
    expect_prog(1, 0, "R7 session first");
    mdl[5] &= 8'h11;
    cmd(8'hAF, 0, 1, 0, 8'h22);
    expect_prog(1, 0, "R8 continuation");
    mdl[6] &= 8'h22;

    // R9 commands while busy discarded
    cmd(8'hAF, 0, 1, 0, 8'h33);
    cmd(8'h04, 0, 0, 0, 8'h00);
    cmd(8'hAF, 0, 1, 0, 8'h00);
    wait_idle();
    mdl[7] &= 8'h33;
    check(aai_o == 1, "R9 aai kept after busy wrdi", aai_o, 1);
    check(wel_clr_o == 0, "R9 no wel_clr", wel_clr_o, 0);

    // R8 continuation with address ignored; R13 02h in session ignored
    cmd(8'hAF, 1, 1, 0, 8'h00);
    expect_prog(0, 0, "R8 continuation with address");
    cmd(8'h02, 1, 1, 0, 8'h00);
    expect_prog(0, 0, "R13 byte prog in session");
    cmd(8'hAF, 0, 1, 0, 8'h44);
    expect_prog(1, 0, "R9 pointer not advanced");
    mdl[8] &= 8'h44;
    cmp_array("R8 R9 R13");

    // R10
    cmd(8'h04, 0, 0, 0, 8'h00);
    check(aai_o == 0, "R10 aai cleared", aai_o, 0);
    check(wel_clr_o == 1, "R10 wel_clr", wel_clr_o, 1);
    wel_i = 0;
    wel_i = 1;
    cmd(8'hAF, 0, 1, 0, 8'h00);
    expect_prog(0, 0, "R8 address-less outside session");
    cmp_array("R10");

    // R12 top of unprotected region
    prot_bound_i = 12; wel_i = 1;
    cmd(8'hAF, 1, 1, 9, 8'h0F);
    expect_prog(1, 0, "R12 byte 9");
    cmd(8'hAF, 0, 1, 0, 8'h1E);
    expect_prog(1, 0, "R12 byte 10");
    cmd(8'hAF, 0, 1, 0, 8'h2D);
    expect_prog(1, 1, "R12 byte 11 exit");
    check(aai_o == 0, "R12 aai exit", aai_o, 0);
    mdl[9] &= 8'h0F; mdl[10] &= 8'h1E; mdl[11] &= 8'h2D;
    cmd(8'hAF, 0, 1, 0, 8'h00);
    expect_prog(0, 0, "R12 after exit");
    prot_bound_i = 16; wel_i = 1;
    cmd(8'hAF, 1, 1, 14, 8'h77);
    expect_prog(1, 0, "R12 byte 14");
    cmd(8'hAF, 0, 1, 0, 8'h66);
    expect_prog(1, 1, "R12 array top exit");
    check(aai_o == 0, "R12 no wrap", aai_o, 0);
    mdl[14] &= 8'h77; mdl[15] &= 8'h66;
    cmd(8'hAF, 0, 1, 0, 8'h00);
    expect_prog(0, 0, "R12 no wrap to 0");
    cmp_array("R12");

    // sweep: boundary x address
    for (int b = 0; b <= 16; b += 4) begin
      prot_bound_i = (AW+1)'(b);
      for (int a = 0; a < DEPTH; a++) begin
        logic [7:0] d;
        d = 8'((a * 37 + b * 11 + 1) ^ 8'hC3);
        wel_i = 1;
        cmd(8'h02, 1, 1, AW'(a), d);
        expect_prog(a < b, 1, "R11 sweep");
        if (a < b) mdl[a] &= d;
      end
      cmp_array("R11 sweep");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule